// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer with Refresh Timer

This block brings an SDRAM device from power-on to a usable state and then keeps it refreshed. A one-cycle `start` pulse launches the sequence. The block first waits a configurable number of idle cycles, so that the required settling pause is met. It then precharges every bank and runs eight auto-refresh cycles. Next it programs the device mode word: burst length one, sequential burst order, and the CAS latency taken from a configuration input. After a short settling delay it declares the memory ready.

Once the memory is ready, a reloadable down-counter paces refresh. The reload value is derived from the clock rate in kHz, so that consecutive refreshes are spaced about 15.6 µs apart. When the counter runs out, the block raises a request. An external arbiter answers with a grant, and the block drives an auto-refresh command on the cycle after the grant. The geometry and bus-width inputs only produce a capacity exponent, which a memory map can use. Command pins are registered. Bank address is always zero during these commands.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. After that edge the command pins read NOP (`{cs_n,ras_n,cas_n,we_n}` = 4'b0111), and `init_done`, `init_pulse` and `ref_req` are 0. The pins stay at NOP until a later `start`.
- R2: If `start` is sampled at edge s, PRECHARGE ALL (4'b0010) is driven after edge s + `cfg_pwr_wait` + 1. It has address bit 10 set, every other address bit 0, and bank 0. Every cycle before it reads NOP.
- R3: Exactly eight AUTO-REFRESH commands (4'b0001, address 0) follow. The first comes `cfg_trp`+1 cycles after the precharge, and each later one comes `cfg_trfc`+1 cycles after the one before. Every command lasts one cycle, with NOP in between.
- R4: LOAD MODE (4'b0000) comes `cfg_trfc`+1 cycles after the eighth refresh. Its address carries `cfg_cas` in bits [6:4], zero in bits [3:0] (burst length 1, sequential), and zero above bit 6. Bank is 0.
- R5: `init_done` rises `cfg_tmrd`+1 cycles after LOAD MODE and stays high until reset. `init_pulse` is high for exactly that first cycle.
- R6: `ref_req` rises reload+1 cycles after `init_done` rises, where reload = floor(156 × `cfg_clk_khz` / 10000).
- R7: `ref_req` stays high until a cycle with `ref_grant` high. After that grant edge, `ref_req` is low and AUTO-REFRESH is driven for one cycle. The next request rises reload+1 cycles after the grant edge.
- R8: A `start` pulse outside the idle state has no effect on any output.
- R9: `cap_log2` = (8+`cfg_col_off`) + (11+`cfg_row_off`) + (1+`cfg_bank_off`) + (`cfg_bus16` ? 1 : 2).

Top module port list in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the power-up sequence from idle |
| cfg_col_off | input | 2 | Column address bits minus 8 |
| cfg_row_off | input | 2 | Row address bits minus 11 |
| cfg_bank_off | input | 1 | Bank address bits minus 1 |
| cfg_bus16 | input | 1 | 1 selects a 16-bit data bus, 0 a 32-bit bus |
| cfg_cas | input | 3 | CAS latency written to the mode word |
| cfg_pwr_wait | input | WAIT_W | Idle cycles before the first command |
| cfg_trp | input | 4 | Precharge recovery, in cycles |
| cfg_trfc | input | 4 | Refresh recovery, in cycles |
| cfg_tmrd | input | 4 | Mode-load settling, in cycles (3 is typical) |
| cfg_clk_khz | input | KHZ_W | Clock frequency in kHz |
| ref_grant | input | 1 | Arbiter grant for a pending refresh |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_pulse | output | 1 | One-cycle marker at the entry to normal mode |
| init_done | output | 1 | Level: memory is ready |
| ref_req | output | 1 | Refresh request, held until granted |
| cap_log2 | output | 6 | log2 of device capacity in bytes |

## Verification
The assertions assume that the configuration inputs stay constant from `start` until the next reset. They also assume that `ref_grant` is only meaningful while `ref_req` is high. The stimulus respects both: each run draws a fresh configuration from a seeded generator while reset is held, and keeps it fixed for the rest of the run. Grants are raised only after a request has been observed, with a random delay of zero to three cycles. Extra `start` pulses are injected both in the middle of the sequence and during normal mode, to exercise R8.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_TRP,
        ST_TRFC,
        ST_TMRD,
        ST_RUN
    } seq_state_e;

    localparam int PRE_ALL_BIT = 10;

    // burst length 1 (000), sequential (0), latency in [6:4]
    function automatic logic [6:0] mode_word(input logic [2:0] cas);
        return {cas, 1'b0, 3'b000};
    endfunction

    // cycles between refreshes for a 15.6 us spacing
    function automatic logic [31:0] refresh_reload(input logic [31:0] khz);
        return (32'd156 * khz) / 32'd10000;
    endfunction

    function automatic logic [5:0] capacity_log2(input logic [1:0] col_off,
                                                 input logic [1:0] row_off,
                                                 input logic       bank_off,
                                                 input logic       bus16);
        return 6'd20 + 6'(col_off) + 6'(row_off) + 6'(bank_off)
                     + (bus16 ? 6'd1 : 6'd2);
    endfunction

endpackage

// File: rtl/sdram_init_wait.sv
module sdram_init_wait #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              zero
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - WAIT_W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [REF_W-1:0] reload,
    input  logic             grant,
    output logic             req,
    output logic             fire
);
    logic             active_q;
    logic [REF_W-1:0] cnt_q;
    logic             req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            req_q    <= 1'b0;
        end else if (arm) begin
            active_q <= 1'b1;
            cnt_q    <= reload;
            req_q    <= 1'b0;
        end else if (active_q) begin
            if (req_q) begin
                if (grant) begin
                    req_q <= 1'b0;
                    cnt_q <= reload;
                end
            end else if (cnt_q == '0) begin
                req_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - REF_W'(1);
            end
        end
    end

    assign req  = req_q;
    assign fire = req_q & grant;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_q && !grant) |=> req_q);                          // R7
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (req_q && grant && !arm) |=> !req_q);                  // R7

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2,
    parameter int WAIT_W    = 16,
    parameter int KHZ_W     = 20,
    parameter int REF_W     = 16,
    parameter int INIT_REFS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cfg_col_off,
    input  logic [1:0]        cfg_row_off,
    input  logic              cfg_bank_off,
    input  logic              cfg_bus16,
    input  logic [2:0]        cfg_cas,
    input  logic [WAIT_W-1:0] cfg_pwr_wait,
    input  logic [3:0]        cfg_trp,
    input  logic [3:0]        cfg_trfc,
    input  logic [3:0]        cfg_tmrd,
    input  logic [KHZ_W-1:0]  cfg_clk_khz,
    input  logic              ref_grant,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_pulse,
    output logic              init_done,
    output logic              ref_req,
    output logic [5:0]        cap_log2
);
    localparam int RC_W = $clog2(INIT_REFS + 1);
    localparam logic [RC_W-1:0] LAST_REF = RC_W'(INIT_REFS - 1);

    seq_state_e        state_q, state_d;
    sd_cmd_e           cmd_q, cmd_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [RC_W-1:0]   nref_q, nref_d;
    logic              done_q, pulse_q, pulse_d;
    logic              w_load, w_zero, arm, ref_fire;
    logic [WAIT_W-1:0] w_val;
    logic [REF_W-1:0]  reload;

    assign reload = REF_W'(refresh_reload(32'(cfg_clk_khz)));

    sdram_init_wait #(.WAIT_W(WAIT_W)) u_wait (
        .clk(clk), .rst(rst), .load(w_load), .load_val(w_val), .zero(w_zero)
    );

    sdram_refresh_timer #(.REF_W(REF_W)) u_refresh (
        .clk(clk), .rst(rst), .arm(arm), .reload(reload),
        .grant(ref_grant), .req(ref_req), .fire(ref_fire)
    );

    always_comb begin
        state_d = state_q;
        cmd_d   = CMD_NOP;
        addr_d  = '0;
        nref_d  = nref_q;
        pulse_d = 1'b0;
        arm     = 1'b0;
        w_load  = 1'b0;
        w_val   = '0;
        case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_PWR;
                w_load  = 1'b1;
                w_val   = cfg_pwr_wait;
            end
            ST_PWR: if (w_zero) begin
                state_d             = ST_TRP;
                cmd_d               = CMD_PRE;
                addr_d[PRE_ALL_BIT] = 1'b1;
                w_load              = 1'b1;
                w_val               = WAIT_W'(cfg_trp);
            end
            ST_TRP: if (w_zero) begin
                state_d = ST_TRFC;
                cmd_d   = CMD_REF;
                nref_d  = '0;
                w_load  = 1'b1;
                w_val   = WAIT_W'(cfg_trfc);
            end
            ST_TRFC: if (w_zero) begin
                w_load = 1'b1;
                if (nref_q == LAST_REF) begin
                    state_d = ST_TMRD;
                    cmd_d   = CMD_LMR;
                    addr_d  = ADDR_W'(mode_word(cfg_cas));
                    w_val   = WAIT_W'(cfg_tmrd);
                end else begin
                    cmd_d  = CMD_REF;
                    nref_d = nref_q + RC_W'(1);
                    w_val  = WAIT_W'(cfg_trfc);
                end
            end
            ST_TMRD: if (w_zero) begin
                state_d = ST_RUN;
                pulse_d = 1'b1;
                arm     = 1'b1;
            end
            ST_RUN: if (ref_fire) cmd_d = CMD_REF;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NOP;
            addr_q  <= '0;
            nref_q  <= '0;
            done_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            nref_q  <= nref_d;
            pulse_q <= pulse_d;
            if (pulse_d) done_q <= 1'b1;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_addr    = addr_q;
    assign sd_ba      = '0;
    assign init_done  = done_q;
    assign init_pulse = pulse_q;
    assign cap_log2   = capacity_log2(cfg_col_off, cfg_row_off, cfg_bank_off, cfg_bus16);

    // checking logic: refreshes seen before ready, reset observation
    logic [RC_W:0] refs_seen_q;
    logic          rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst)
            refs_seen_q <= '0;
        else if (cmd_q == CMD_REF && !done_q)
            refs_seen_q <= refs_seen_q + (RC_W+1)'(1);
    end

    always_comb begin
        if (rst_seen_q)
            AST_RESET_IDLE: assert (cmd_q == CMD_NOP && !done_q && !pulse_q && !ref_req); // R1
    end

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_PRE) |-> (sd_addr[PRE_ALL_BIT] && sd_ba == '0));       // R2
    AST_INIT_REF_COUNT: assert property (@(posedge clk) disable iff (rst)
        init_pulse |-> (refs_seen_q == (RC_W+1)'(INIT_REFS)));                // R3
    AST_MODE_BURST: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_LMR) |-> (sd_addr[3:0] == 4'b0000));                    // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);                                             // R5
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        init_pulse |=> !init_pulse);                                          // R5
    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> init_pulse);                                     // R5

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int WAIT_W = 16;
    localparam int KHZ_W  = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        cfg_col_off = '0;
    logic [1:0]        cfg_row_off = '0;
    logic              cfg_bank_off = 1'b0;
    logic              cfg_bus16 = 1'b0;
    logic [2:0]        cfg_cas = 3'd2;
    logic [WAIT_W-1:0] cfg_pwr_wait = '0;
    logic [3:0]        cfg_trp = 4'd2;
    logic [3:0]        cfg_trfc = 4'd4;
    logic [3:0]        cfg_tmrd = 4'd3;
    logic [KHZ_W-1:0]  cfg_clk_khz = 20'd1000;
    logic              ref_grant = 1'b0;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BA_W-1:0]   sd_ba;
    logic [ADDR_W-1:0] sd_addr;
    logic              init_pulse, init_done, ref_req;
    logic [5:0]        cap_log2;

    sdram_init_seq dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_col_off(cfg_col_off), .cfg_row_off(cfg_row_off),
        .cfg_bank_off(cfg_bank_off), .cfg_bus16(cfg_bus16), .cfg_cas(cfg_cas),
        .cfg_pwr_wait(cfg_pwr_wait), .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc),
        .cfg_tmrd(cfg_tmrd), .cfg_clk_khz(cfg_clk_khz), .ref_grant(ref_grant),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .init_pulse(init_pulse), .init_done(init_done), .ref_req(ref_req),
        .cap_log2(cap_log2)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_LMR = 4'b0000;

    function automatic int exp_reload(input int khz);
        return (156 * khz) / 10000;
    endfunction

    function automatic int exp_cap(input int co, input int ro, input int bo, input bit b16);
        return (8 + co) + (11 + ro) + (1 + bo) + (b16 ? 1 : 2);
    endfunction

    function automatic logic [3:0] cmd_now();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        ref_grant = 1'b0;
        repeat (2) @(negedge clk);
        check(cmd_now() == K_NOP, "R1 reset command", cmd_now(), K_NOP);
        check({init_done, init_pulse, ref_req} == 3'b000, "R1 reset flags",
              {init_done, init_pulse, ref_req}, 0);
        rst = 1'b0;
    endtask

    // Runs the full power-up and three refresh grants, compares each cycle.
    task automatic run_seq(input int pwr, input int trp, input int trfc, input int tmrd,
                           input int cas, input int khz, input bit inject);
        int s, tp, tl, td, tq, rl, g;
        int tr[8];
        int bad2, bad3, bad4, bad5, bad6, bad7;
        int a2, e2, a3, e3, a4, e4, a5, e5, a6, e6, a7, e7;
        bad2 = 0; bad3 = 0; bad4 = 0; bad5 = 0; bad6 = 0; bad7 = 0;
        a2 = 0; e2 = 0; a3 = 0; e3 = 0; a4 = 0; e4 = 0;
        a5 = 0; e5 = 0; a6 = 0; e6 = 0; a7 = 0; e7 = 0;
        cfg_pwr_wait = WAIT_W'(pwr);
        cfg_trp  = 4'(trp);
        cfg_trfc = 4'(trfc);
        cfg_tmrd = 4'(tmrd);
        cfg_cas  = 3'(cas);
        cfg_clk_khz = KHZ_W'(khz);
        do_reset();
        rl = exp_reload(khz);
        @(negedge clk);
        start = 1'b1;
        s = cyc + 1;
        tp = s + pwr + 1;
        for (int i = 0; i < 8; i++) tr[i] = tp + trp + 1 + i * (trfc + 1);
        tl = tr[7] + trfc + 1;
        td = tl + tmrd + 1;
        tq = td + rl + 1;
        @(negedge clk);
        start = 1'b0;
        while (cyc <= tq) begin
            logic [3:0] ek;
            logic [ADDR_W-1:0] ea;
            bit is_ref;
            is_ref = 1'b0;
            for (int i = 0; i < 8; i++) if (cyc == tr[i]) is_ref = 1'b1;
            ek = K_NOP;
            ea = '0;
            if (cyc == tp) begin ek = K_PRE; ea = ADDR_W'(1 << 10); end
            else if (is_ref) ek = K_REF;
            else if (cyc == tl) begin ek = K_LMR; ea = ADDR_W'(cas << 4); end
            if (cmd_now() != ek || sd_addr != ea || sd_ba != '0) begin
                if (ek == K_PRE || cmd_now() == K_PRE) begin
                    if (bad2 == 0) begin a2 = {cmd_now(), sd_addr}; e2 = {ek, ea}; end
                    bad2++;
                end else if (ek == K_LMR || cmd_now() == K_LMR) begin
                    if (bad4 == 0) begin a4 = {cmd_now(), sd_addr}; e4 = {ek, ea}; end
                    bad4++;
                end else begin
                    if (bad3 == 0) begin a3 = {cmd_now(), sd_addr}; e3 = {ek, ea}; end
                    bad3++;
                end
            end
            if (init_done != (cyc >= td) || init_pulse != (cyc == td)) begin
                if (bad5 == 0) begin a5 = {init_done, init_pulse}; e5 = {(cyc >= td), (cyc == td)}; end
                bad5++;
            end
            if (ref_req != (cyc >= tq)) begin
                if (bad6 == 0) begin a6 = ref_req; e6 = (cyc >= tq); end
                bad6++;
            end
            start = inject && (cyc == s + 2 || cyc == tl + 1 || cyc == td + 1);
            @(negedge clk);
        end
        start = 1'b0;
        // refresh service, grant after a random delay
        for (int k = 0; k < 3; k++) begin
            int dly;
            dly = int'($urandom_range(3, 0));
            for (int d = 0; d < dly; d++) begin
                if (!ref_req || cmd_now() != K_NOP) begin
                    if (bad7 == 0) begin a7 = {ref_req, cmd_now()}; e7 = {1'b1, K_NOP}; end
                    bad7++;
                end
                start = inject;
                @(negedge clk);
                start = 1'b0;
            end
            ref_grant = 1'b1;
            g = cyc + 1;
            @(negedge clk);
            ref_grant = 1'b0;
            if (ref_req || cmd_now() != K_REF) begin
                if (bad7 == 0) begin a7 = {ref_req, cmd_now()}; e7 = {1'b0, K_REF}; end
                bad7++;
            end
            @(negedge clk);
            while (cyc <= g + rl + 1) begin
                if (ref_req != (cyc == g + rl + 1) || cmd_now() != K_NOP) begin
                    if (bad7 == 0) begin a7 = {ref_req, cmd_now()}; e7 = {(cyc == g + rl + 1), K_NOP}; end
                    bad7++;
                end
                if (cyc != g + rl + 1) @(negedge clk);
                else break;
            end
        end
        check(bad2 == 0, "R2 precharge all timing/address", a2, e2);
        check(bad3 == 0, "R3 eight auto-refresh spacing", a3, e3);
        check(bad4 == 0, "R4 load mode timing/word", a4, e4);
        check(bad5 == 0, "R5 ready flag and pulse", a5, e5);
        check(bad6 == 0, "R6 first refresh request", a6, e6);
        check(bad7 == 0, "R7 request hold and grant", a7, e7);
        if (inject)
            check(bad2 + bad3 + bad4 + bad5 + bad6 + bad7 == 0, "R8 stray start ignored",
                  bad2 + bad3 + bad4 + bad5 + bad6 + bad7, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // directed: typical settling of 3, latency 3
        run_seq(50, 2, 6, 3, 3, 250, 1'b0);
        // directed: zero waits everywhere, stray start pulses
        run_seq(0, 0, 0, 0, 2, 700, 1'b1);
        // random configurations
        for (int r = 0; r < 5; r++) begin
            run_seq(int'($urandom_range(40, 3)), int'($urandom_range(7, 1)),
                    int'($urandom_range(15, 1)), int'($urandom_range(7, 1)),
                    int'($urandom_range(3, 1)), int'($urandom_range(2000, 500)),
                    bit'(r % 2));
        end
        // reset in the middle of the refresh burst, then stay idle
        cfg_pwr_wait = WAIT_W'(4);
        cfg_trp = 4'd1;
        cfg_trfc = 4'd3;
        do_reset();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(cmd_now() == K_NOP && !init_done && !ref_req, "R1 mid-sequence reset",
              {cmd_now(), init_done, ref_req}, {K_NOP, 2'b00});
        begin
            int busy;
            busy = 0;
            repeat (60) begin
                @(negedge clk);
                if (cmd_now() != K_NOP) busy++;
            end
            check(busy == 0, "R1 idle after reset", busy, 0);
        end
        // capacity exponent
        for (int c = 0; c < 10; c++) begin
            int co, ro, bo;
            bit b16;
            co = int'($urandom_range(3, 0));
            ro = int'($urandom_range(3, 0));
            bo = int'($urandom_range(1, 0));
            b16 = bit'($urandom_range(1, 0));
            if (c == 0) begin co = 3; ro = 3; bo = 1; b16 = 1'b0; end
            cfg_col_off = 2'(co);
            cfg_row_off = 2'(ro);
            cfg_bank_off = 1'(bo);
            cfg_bus16 = b16;
            @(negedge clk);
            check(int'(cap_log2) == exp_cap(co, ro, bo, b16), "R9 capacity exponent",
                  int'(cap_log2), exp_cap(co, ro, bo, b16));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule